// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block produces the core reset and the core clock-release signal for a chip. Two things can start a reset: an active-low external reset pin and a one-cycle or level reset request from a watchdog. The pin is first synchronized and then debounced by a digital glitch filter, so a short pulse on the pin has no effect. Once a reset has started, the core stays in reset until four things are true at the same time: the filtered pin is released, the oscillator reports a valid clock, a stabilization counter has seen a programmed number of oscillator cycles, and the on-chip initialization reports done.

The same stabilization counter also handles wake-up from power-down. A power-down exit request drops the clock release while leaving the core out of reset. The clock comes back only after the oscillator has again been counted stable. A sticky cause register records whether the pin or the watchdog caused the reset. Software clears it by writing ones. When the core leaves reset, the fetch address presented to it is the reset vector, zero by default. A separate active-low power-on reset asserts the core reset at once, without waiting for a clock. Deassertion always follows the clock.

Top module: `rst_wake_seq`

## Requirements
- R1: When the filtered pin is asserted or `wdtRstReq` is high at a clock edge, `coreRstN` is low after that edge. This holds in every state.
- R2: The pin passes through `SYNC_STAGES` flip-flops and then a filter. The filtered level changes only after the synchronized level has differed from it on `FILT_LEN` consecutive clock edges. A low pulse that spans fewer samples causes no reset.
- R3: `coreRstN` rises on the edge after a cycle in which all of these hold at once: the filtered pin is released, there is no watchdog request, `oscValid` is high, the stabilization count is complete and `initDone` is high.
- R4: A `pdExitReq` while running drops `clkRelease` on the next edge and restarts the stabilization count, with `coreRstN` staying high. `clkRelease` returns on the edge after a cycle that has `oscValid` high and the count complete.
- R5: `fetchAddr` equals `RESET_VECTOR` (default 0x00000000) whenever `coreRstN` is high.
- R6: The stabilization counter advances by one per clock while `oscValid` is high and stops at `STAB_CYCLES`. It is zero after any edge at which `oscValid` is low or a restart is requested.
- R7: `rstCause` bit 0 records a pin reset and bit 1 records a watchdog reset. Each bit is set while its source is active and stays set afterwards. A cycle with `causeClrWe` high clears each bit whose `causeClrData` bit is one. Setting wins over clearing.
- R8: `porRstN` low forces `coreRstN` low and `clkRelease` low without a clock edge, and clears `rstCause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived system clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| extRstPinN | input | 1 | External reset pin level, active low, asynchronous |
| wdtRstReq | input | 1 | Watchdog reset request |
| oscValid | input | 1 | Oscillator running indication |
| initDone | input | 1 | On-chip initialization finished |
| pdExitReq | input | 1 | Request to leave power-down |
| causeClrWe | input | 1 | Write strobe for clearing cause bits |
| causeClrData | input | 2 | Ones clear the matching cause bits |
| coreRstN | output | 1 | Core reset, active low |
| clkRelease | output | 1 | Core clocks enabled |
| fetchAddr | output | 32 | First fetch address after reset |
| rstCause | output | 2 | Sticky cause: bit 0 pin, bit 1 watchdog |

## Verification
The bench builds the block with `STAB_CYCLES` set to 16 and keeps `FILT_LEN` at 4. The smaller count makes complete reset releases, restarts after an oscillator drop, and wake-ups from power-down short enough to run many times in one test. With a filter length of 4, a pin pulse that gives three samples can be checked to be ignored and one that gives five samples can be checked to cause a reset.

// File: rtl/rst_wake_pkg.sv
package rst_wake_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAKE = 2'd2
  } seqState_e;

  typedef struct packed {
    logic stabClear;
  } seqStrobe_t;
endpackage

// File: rtl/rst_wake_dp.sv
module rst_wake_dp
  import rst_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int STAB_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinN,
  input  logic       wdtReq,
  input  logic       oscValid,
  input  seqStrobe_t strb,
  input  logic       causeClrWe,
  input  logic [1:0] causeClrData,
  output logic       pinAsserted,
  output logic       stabDone,
  output logic [1:0] rstCause
);
  localparam int FW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam int SW = $clog2(STAB_CYCLES + 1);
  localparam logic [FW-1:0] FILT_MAX = FW'(FILT_LEN - 1);
  localparam logic [SW-1:0] STAB_MAX = SW'(STAB_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncPin;
  logic filtLevel;
  logic [FW-1:0] filtCnt;
  logic [SW-1:0] stabCnt;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else if (g == 0) syncChain[g] <= pinN;
        else syncChain[g] <= syncChain[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate
  assign syncPin = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLevel <= 1'b0;
      filtCnt   <= '0;
    end else if (syncPin == filtLevel) begin
      filtCnt <= '0;
    end else if (filtCnt == FILT_MAX) begin
      filtLevel <= syncPin;
      filtCnt   <= '0;
    end else begin
      filtCnt <= filtCnt + 1'b1;
    end
  end
  assign pinAsserted = ~filtLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stabCnt <= '0;
    else if (strb.stabClear || !oscValid) stabCnt <= '0;
    else if (stabCnt != STAB_MAX) stabCnt <= stabCnt + 1'b1;
  end
  assign stabDone = (stabCnt == STAB_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstCause <= 2'b00;
    else begin
      if (pinAsserted) rstCause[0] <= 1'b1;
      else if (causeClrWe && causeClrData[0]) rstCause[0] <= 1'b0;
      if (wdtReq) rstCause[1] <= 1'b1;
      else if (causeClrWe && causeClrData[1]) rstCause[1] <= 1'b0;
    end
  end

  p_filter_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (filtLevel != $past(filtLevel)) |-> ($past(filtCnt) == FILT_MAX));
  p_stab_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    stabCnt <= STAB_MAX);
  p_osc_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    !oscValid |=> (stabCnt == '0));
  p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rstCause[1] && !causeClrWe) |=> rstCause[1]);
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
  import rst_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinAsserted,
  input  logic       wdtReq,
  input  logic       oscValid,
  input  logic       initDone,
  input  logic       pdExitReq,
  input  logic       stabDone,
  output seqStrobe_t strb,
  output logic       coreRstN,
  output logic       clkRelease
);
  seqState_e state, nxt;
  logic rstEvent;

  assign rstEvent = pinAsserted | wdtReq;

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_HOLD: begin
        strb.stabClear = rstEvent;
        if (!rstEvent && oscValid && stabDone && initDone) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (rstEvent) begin
          nxt = ST_HOLD;
          strb.stabClear = 1'b1;
        end else if (pdExitReq) begin
          nxt = ST_WAKE;
          strb.stabClear = 1'b1;
        end
      end
      ST_WAKE: begin
        if (rstEvent) begin
          nxt = ST_HOLD;
          strb.stabClear = 1'b1;
        end else if (oscValid && stabDone) begin
          nxt = ST_RUN;
        end
      end
      default: nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else state <= nxt;
  end

  assign coreRstN   = (state != ST_HOLD);
  assign clkRelease = (state == ST_RUN);

  p_source_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wdtReq || pinAsserted) |=> !coreRstN);
  p_release_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstN) |-> $past(oscValid && stabDone && initDone));
  p_pdexit_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkRelease && pdExitReq && !rstEvent) |=> (!clkRelease && coreRstN));
  p_wake_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRelease) |-> $past(oscValid && stabDone));
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq
  import rst_wake_pkg::*;
#(
  parameter int          SYNC_STAGES  = 2,
  parameter int          FILT_LEN     = 4,
  parameter int          STAB_CYCLES  = 4096,
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              extRstPinN,
  input  logic              wdtRstReq,
  input  logic              oscValid,
  input  logic              initDone,
  input  logic              pdExitReq,
  input  logic              causeClrWe,
  input  logic [1:0]        causeClrData,
  output logic              coreRstN,
  output logic              clkRelease,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [1:0]        rstCause
);
  seqStrobe_t strb;
  logic pinAsserted;
  logic stabDone;

  rst_wake_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN(FILT_LEN),
    .STAB_CYCLES(STAB_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(porRstN), .pinN(extRstPinN), .wdtReq(wdtRstReq),
    .oscValid(oscValid), .strb(strb), .causeClrWe(causeClrWe),
    .causeClrData(causeClrData), .pinAsserted(pinAsserted),
    .stabDone(stabDone), .rstCause(rstCause)
  );

  rst_wake_ctrl ctrl_i (
    .clk(clk), .rstN(porRstN), .pinAsserted(pinAsserted), .wdtReq(wdtRstReq),
    .oscValid(oscValid), .initDone(initDone), .pdExitReq(pdExitReq),
    .stabDone(stabDone), .strb(strb), .coreRstN(coreRstN),
    .clkRelease(clkRelease)
  );

  assign fetchAddr = RESET_VECTOR[ADDR_W-1:0];
endmodule

// File: tb/rst_wake_seq_tb_top.sv
module rst_wake_seq_tb_top;
  localparam int STAB = 16;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic porRstN = 1'b0, extRstPinN = 1'b0, wdtRstReq = 1'b0;
  logic oscValid = 1'b0, initDone = 1'b0, pdExitReq = 1'b0;
  logic causeClrWe = 1'b0;
  logic [1:0] causeClrData = 2'b00;
  logic coreRstN, clkRelease;
  logic [31:0] fetchAddr;
  logic [1:0] rstCause;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  rst_wake_seq #(.STAB_CYCLES(STAB), .FILT_LEN(FILT)) dut_i (
    .clk(clk), .porRstN(porRstN), .extRstPinN(extRstPinN),
    .wdtRstReq(wdtRstReq), .oscValid(oscValid), .initDone(initDone),
    .pdExitReq(pdExitReq), .causeClrWe(causeClrWe),
    .causeClrData(causeClrData), .coreRstN(coreRstN),
    .clkRelease(clkRelease), .fetchAddr(fetchAddr), .rstCause(rstCause)
  );

  always #10 clk = ~clk;

  // behavioural reference: integers, 0=hold 1=run 2=wake
  int mS1, mS2, mFilt, mFc, mCnt, mState, mCause;
  always @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      mS1 = 0; mS2 = 0; mFilt = 0; mFc = 0; mCnt = 0; mState = 0; mCause = 0;
    end else begin
      int ev, clr, nState, nFilt, nFc, nCnt, nCause;
      ev = (mFilt == 0 || wdtRstReq) ? 1 : 0;
      clr = 0;
      nState = mState;
      if (mState == 0) begin
        clr = ev;
        if (!ev && oscValid && mCnt == STAB && initDone) nState = 1;
      end else if (ev) begin
        clr = 1; nState = 0;
      end else if (mState == 1 && pdExitReq) begin
        clr = 1; nState = 2;
      end else if (mState == 2 && oscValid && mCnt == STAB) begin
        nState = 1;
      end
      if (clr || !oscValid) nCnt = 0;
      else nCnt = (mCnt < STAB) ? mCnt + 1 : mCnt;
      nFilt = mFilt; nFc = 0;
      if (mS2 != mFilt) begin
        if (mFc == FILT - 1) nFilt = mS2;
        else nFc = mFc + 1;
      end
      nCause = mCause;
      if (mFilt == 0) nCause = nCause | 1;
      else if (causeClrWe && causeClrData[0]) nCause = nCause & 2;
      if (wdtRstReq) nCause = nCause | 2;
      else if (causeClrWe && causeClrData[1]) nCause = nCause & 1;
      mS2 = mS1; mS1 = int'(extRstPinN);
      mFilt = nFilt; mFc = nFc; mCnt = nCnt; mState = nState; mCause = nCause;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(int'(coreRstN) == int'(mState != 0), "R3 coreRstN vs model", int'(coreRstN), int'(mState != 0));
    check(int'(clkRelease) == int'(mState == 1), "R4 clkRelease vs model", int'(clkRelease), int'(mState == 1));
    check(int'(rstCause) == mCause, "R7 rstCause vs model", int'(rstCause), mCause);
    if (coreRstN) check(fetchAddr == 32'h0, "R5 fetchAddr", int'(fetchAddr), 0);
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    while (cycles < 20000) @(posedge clk);
    check(1'b0, "watchdog expired", cycles, 20000);
    finishRun();
  end

  initial begin
    #1;
    check(coreRstN == 1'b0 && clkRelease == 1'b0, "R8 reset state", int'(coreRstN), 0);
    check(rstCause == 2'b00, "R8 cause cleared", int'(rstCause), 0);
    waitCyc(2);
    porRstN = 1'b1;
    waitCyc(5);
    extRstPinN = 1'b1; oscValid = 1'b1;
    waitCyc(40);
    check(coreRstN == 1'b0, "R3 held without initDone", int'(coreRstN), 0);
    initDone = 1'b1;
    waitCyc(2);
    check(coreRstN == 1'b1, "R3 released", int'(coreRstN), 1);
    check(fetchAddr == 32'h0, "R5 vector at release", int'(fetchAddr), 0);
    check(rstCause == 2'b01, "R7 pin cause from power-up", int'(rstCause), 1);
    causeClrWe = 1'b1; causeClrData = 2'b11;
    waitCyc(1);
    causeClrWe = 1'b0; causeClrData = 2'b00;
    waitCyc(1);
    check(rstCause == 2'b00, "R7 write-one clear", int'(rstCause), 0);
    // 3-sample glitch must be ignored
    extRstPinN = 1'b0;
    waitCyc(3);
    extRstPinN = 1'b1;
    for (int i = 0; i < 10; i++) begin
      waitCyc(1);
      check(coreRstN == 1'b1, "R2 short glitch ignored", int'(coreRstN), 1);
    end
    check(rstCause == 2'b00, "R2 glitch leaves cause", int'(rstCause), 0);
    // 5-sample pulse resets
    extRstPinN = 1'b0;
    waitCyc(5);
    extRstPinN = 1'b1;
    waitCyc(3);
    check(coreRstN == 1'b0, "R1 pin reset", int'(coreRstN), 0);
    check(rstCause[0] == 1'b1, "R7 pin cause set", int'(rstCause), 1);
    waitCyc(40);
    check(coreRstN == 1'b1, "R3 release after pin", int'(coreRstN), 1);
    // watchdog pulse with oscillator drop during hold
    wdtRstReq = 1'b1;
    waitCyc(1);
    wdtRstReq = 1'b0;
    check(coreRstN == 1'b0, "R1 watchdog reset", int'(coreRstN), 0);
    check(rstCause == 2'b11, "R7 watchdog cause", int'(rstCause), 3);
    waitCyc(10);
    oscValid = 1'b0;
    waitCyc(3);
    oscValid = 1'b1;
    waitCyc(10);
    check(coreRstN == 1'b0, "R6 oscillator drop restarts count", int'(coreRstN), 0);
    waitCyc(40);
    check(coreRstN == 1'b1, "R3 release after watchdog", int'(coreRstN), 1);
    // power-down exit
    pdExitReq = 1'b1;
    waitCyc(1);
    pdExitReq = 1'b0;
    check(clkRelease == 1'b0 && coreRstN == 1'b1, "R4 clocks gated on wake", int'(clkRelease), 0);
    waitCyc(10);
    check(clkRelease == 1'b0, "R4 still counting", int'(clkRelease), 0);
    waitCyc(10);
    check(clkRelease == 1'b1, "R4 clocks back", int'(clkRelease), 1);
    // asynchronous power-on reset mid-run
    #5 porRstN = 1'b0;
    #1;
    check(coreRstN == 1'b0 && clkRelease == 1'b0, "R8 async assert", int'(coreRstN), 0);
    check(rstCause == 2'b00, "R8 cause cleared", int'(rstCause), 0);
    waitCyc(2);
    porRstN = 1'b1;
    waitCyc(50);
    check(coreRstN == 1'b1, "R3 release after power-on", int'(coreRstN), 1);
    finishRun();
  end
endmodule